// File: doc/BRIEF.md
# Serial Master Port with Frame FIFOs

This block is a synchronous serial master that software drives through six memory-mapped registers. Words written to the data register queue in a transmit FIFO. The shift engine takes them one at a time and sends each one MSB first on `mosi` while it toggles `sclk`. During each frame it holds the frame strobe `ss_n` low. It samples `miso`, or the block's own output in loopback, and stores each completed frame in a receive FIFO. Software reads those frames back through the same data address.

Frame length runs from 4 to 16 bits. Clock polarity and phase can each be selected. The bit clock comes from two cascaded dividers: an even prescaler, followed by a rate divider that divides by one plus its setting. A status register shows the FIFO fill conditions and activity. Three interrupt sources (receive level, transmit level, receive overrun) are each masked by an enable bit and combined into one `irq` line. Writing any value to the interrupt address clears the overrun condition.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset every configuration register reads zero, status (0x0C) reads 0x0003, `irq` is low, `ss_n` is high and `sclk` is low.
- R2: Byte offsets: 0x00 format (all 16 bits read back), 0x04 control (bits 6:0 read back), 0x08 data, 0x0C status, 0x10 prescale (bits 7:1 stored, bit 0 reads zero), 0x14 interrupt.
- R3: Each `sclk` half-period lasts (P/2)*(1+S) clocks, where P is the prescale value and S is format[15:8]. A P below 2 behaves as 2. The first edge of a frame comes that many clocks after `ss_n` falls.
- R4: format[3:0] holds bits-per-frame minus one, so codes 3..15 give 4..16 bits and codes 0..2 act as 4 bits. Data goes out MSB first. `ss_n` is low for exactly one frame and goes high for at least one clock between frames.
- R5: format[7] sets the idle level of `sclk`. With format[6]=0 both sides sample on the leading edge, the first edge away from idle. With format[6]=1 they sample on the trailing edge.
- R6: The transmit FIFO holds DEPTH (8) words. A data write while it is full is discarded.
- R7: A data read returns the oldest received frame right-aligned and zero-extended, and removes it. A read while the receive FIFO is empty returns 0.
- R8: Status bits: bit0 transmit FIFO empty, bit1 transmit FIFO not full, bit2 receive FIFO not empty, bit3 receive FIFO full, bit4 busy (a frame in flight or transmit data waiting).
- R9: A frame that completes while the receive FIFO is full is dropped and sets the overrun flag. Reading 0x14 gives bit2 = overrun AND control bit2. Any write to 0x14 clears the flag.
- R10: In the 0x14 read, bit0 = (receive count >= DEPTH/2) AND control bit0, and bit1 = (transmit count <= DEPTH/2) AND control bit1. `irq` is the OR of bits 2:0.
- R11: With control bit3 set, the receiver takes the block's own `mosi` bits and `miso` has no effect.
- R12: Control bit4 enables the port. Clearing it abandons the current frame: on the next clock `ss_n` is high, `sclk` is at idle, and nothing is stored. While the port is disabled, queued transmit data stays in the FIFO and is not sent. Control bits 5 and 6 are stored but have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the access cycle |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Frame strobe, low during a frame |
| miso | input | 1 | Serial data in |

## Verification
The in-RTL assertions take for granted that every register access is a single-cycle `reg_en` pulse. They also assume the format and prescale registers are left unchanged while a frame is in flight, because a mid-frame change of length or polarity would make the edge count meaningless. The bench respects this: it reprograms format and prescale only after the status busy bit reads zero, or while the port is disabled. It holds `miso` constant during each external-input frame, so the received value is known without modelling a slave.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic        ss_n,
  input  logic        miso
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH/2);

  logic [15:0] fmt_q;
  logic [6:0]  ctl_q;
  logic [7:0]  pre_q;
  logic        ovr_q;

  wire [7:0] scr     = fmt_q[15:8];
  wire       cpol    = fmt_q[7];
  wire       cpha    = fmt_q[6];
  wire [3:0] nm1     = (fmt_q[3:0] < 4'd3) ? 4'd3 : fmt_q[3:0];
  wire       port_en = ctl_q[4];
  wire       lbk     = ctl_q[3];

  wire wr      = reg_en && reg_we;
  wire rd      = reg_en && !reg_we;
  wire wr_data = wr && (reg_addr == 5'h08);
  wire rd_data = rd && (reg_addr == 5'h08);
  wire wr_clr  = wr && (reg_addr == 5'h14);

  logic [15:0] tx_mem [DEPTH];
  logic [15:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;

  logic        act_q, sclk_q, mosi_q;
  logic [4:0]  edge_q;
  logic [15:0] tx_sh, rx_sh;
  logic [6:0]  div_pre;
  logic [7:0]  div_scr;

  wire [6:0]  half_m1 = (pre_q[7:1] == 7'd0) ? 7'd0 : pre_q[7:1] - 7'd1;
  wire        start   = port_en && !act_q && (tx_cnt != '0);
  wire        tick    = act_q && (div_pre == half_m1) && (div_scr == scr);
  wire        lead    = !edge_q[0];
  wire        smp     = tick && (lead != cpha);
  wire        shf     = tick && (lead == cpha);
  wire        done    = tick && (edge_q == {nm1, 1'b1});
  wire        din     = lbk ? mosi_q : miso;
  wire [15:0] rx_nxt  = smp ? {rx_sh[14:0], din} : rx_sh;
  wire [15:0] mask    = 16'hFFFF >> (4'd15 - nm1);
  wire [15:0] aligned = tx_mem[tx_rp] << (4'd15 - nm1);

  wire tx_push = wr_data && (tx_cnt != FULL);
  wire tx_pop  = start;
  wire rx_push = done && (rx_cnt != FULL);
  wire rx_pop  = rd_data && (rx_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
      ctl_q <= '0;
      pre_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (wr && reg_addr == 5'h00) fmt_q <= reg_wdata;
      if (wr && reg_addr == 5'h04) ctl_q <= reg_wdata[6:0];
      if (wr && reg_addr == 5'h10) pre_q <= {reg_wdata[7:1], 1'b0};
      if (wr_clr) ovr_q <= 1'b0;
      if (done && rx_cnt == FULL) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_nxt & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pre <= '0;
      div_scr <= '0;
    end else if (!act_q || tick) begin
      div_pre <= '0;
      div_scr <= '0;
    end else if (div_pre == half_m1) begin
      div_pre <= '0;
      div_scr <= div_scr + 8'd1;
    end else begin
      div_pre <= div_pre + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (!port_en) begin
      act_q <= 1'b0;
    end else if (start) begin
      act_q  <= 1'b1;
      edge_q <= '0;
      sclk_q <= cpol;
      rx_sh  <= '0;
      if (!cpha) begin
        mosi_q <= aligned[15];
        tx_sh  <= aligned << 1;
      end else begin
        tx_sh  <= aligned;
      end
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 5'd1;
      rx_sh  <= rx_nxt;
      if (shf) begin
        mosi_q <= tx_sh[15];
        tx_sh  <= tx_sh << 1;
      end
      if (done) act_q <= 1'b0;
    end
  end

  wire [2:0] irq_vec = {ovr_q & ctl_q[2],
                        (tx_cnt <= HALF) & ctl_q[1],
                        (rx_cnt >= HALF) & ctl_q[0]};
  wire [4:0] stat = {act_q || (tx_cnt != '0), rx_cnt == FULL, rx_cnt != '0,
                     tx_cnt != FULL, tx_cnt == '0};

  assign irq  = |irq_vec;
  assign sclk = act_q ? sclk_q : cpol;
  assign mosi = mosi_q;
  assign ss_n = !act_q;

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      case (reg_addr)
        5'h00:   reg_rdata = fmt_q;
        5'h04:   reg_rdata = {9'd0, ctl_q};
        5'h08:   reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 16'd0;
        5'h0C:   reg_rdata = {11'd0, stat};
        5'h10:   reg_rdata = {8'd0, pre_q};
        5'h14:   reg_rdata = {13'd0, irq_vec};
        default: reg_rdata = '0;
      endcase
    end
  end

  assert_tx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  assert_full_write_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_cnt == FULL && !tx_pop) |=> tx_cnt == FULL);
  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_cnt == FULL) |=> ovr_q);
  assert_ovr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_cnt == FULL && !rx_pop) |=> rx_cnt == FULL);
  assert_stop_on_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> ss_n);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2:0] == 3'd0) |-> !irq);
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        r_en = 1'b0, r_we = 1'b0;
  logic [4:0]  r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic        miso = 1'b0;
  wire  [15:0] r_rdata;
  wire         irq, sclk, mosi, ss_n;

  spi_fifo_master #(.DEPTH(8)) i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .reg_en(r_en), .reg_we(r_we), .reg_addr(r_addr),
    .reg_wdata(r_wdata), .reg_rdata(r_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] wire_q[$];
  int   m_bits = 8;
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  logic [15:0] m_sh = '0;
  int   m_cnt = 0;
  logic p_sclk = 1'b0, p_ss = 1'b1;

  function automatic logic [15:0] msk(input int b);
    return 16'hFFFF >> (16 - b);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); r_en = 1'b1; r_we = 1'b1; r_addr = a; r_wdata = d;
    @(negedge clk); r_en = 1'b0; r_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); r_en = 1'b1; r_we = 1'b0; r_addr = a;
    #1 d = r_rdata;
    @(negedge clk); r_en = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] f, input logic [15:0] p, input logic [15:0] c);
    m_bits = (f[3:0] < 4'd3) ? 4 : int'(f[3:0]) + 1;
    m_cpol = f[7]; m_cpha = f[6];
    wr(5'h00, f); wr(5'h10, p); wr(5'h04, c);
  endtask

  task automatic send(input logic [15:0] w);
    wire_q.push_back(w & msk(m_bits));
    wr(5'h08, w);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do rd(5'h0C, s); while (s[4]);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_rx(input string req, input logic [15:0] exp);
    logic [15:0] d;
    rd(5'h08, d);
    check(req, d, exp);
  endtask

  task automatic measure(input string req, input logic [15:0] w, input int exp);
    int cnt;
    send(w);
    while (ss_n) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclk == m_cpol);
    check(req, 16'(cnt), 16'(exp));
    wait_idle();
    expect_rx("R11 loopback data", w & msk(m_bits));
  endtask

  // scoreboard monitor: rebuild each frame from the sampling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk !== p_sclk && (!ss_n || !p_ss)) begin
        if ((sclk != m_cpol) != m_cpha) begin
          m_sh = {m_sh[14:0], mosi};
          m_cnt++;
        end
      end
      if (ss_n && !p_ss) begin
        if (m_cnt == m_bits) begin
          if (wire_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R4 unexpected frame actual=%h expected=none", m_sh & msk(m_bits));
          end else begin
            check("R4 R5 serial frame", m_sh & msk(m_bits), wire_q.pop_front());
          end
        end
        m_cnt = 0;
      end
    end
    p_sclk = sclk; p_ss = ss_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(5'h0C, d); check("R1 status", d, 16'h0003);
    rd(5'h04, d); check("R1 control", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 ss_n", {15'd0, ss_n}, 16'd1);
    check("R1 sclk", {15'd0, sclk}, 16'd0);

    // R2 register readback
    wr(5'h00, 16'h12C5); rd(5'h00, d); check("R2 format", d, 16'h12C5);
    wr(5'h04, 16'h006F); rd(5'h04, d); check("R2 control", d, 16'h006F);
    wr(5'h04, 16'h0000);
    wr(5'h10, 16'h0007); rd(5'h10, d); check("R2 prescale bit0", d, 16'h0006);

    // R3 bit rate, in loopback with miso high (R11)
    miso = 1'b1;
    cfg(16'h0207, 16'd4, 16'h0018);  measure("R3 half period P4 S2", 16'h00A5, 6);
    cfg(16'h0007, 16'd0, 16'h0018);  measure("R3 half period P0 S0", 16'h003C, 1);
    cfg(16'h0007, 16'd10, 16'h0018); measure("R3 half period P10 S0", 16'h0081, 5);

    // R5 mode 3, 16-bit, external input held low
    miso = 1'b0;
    cfg(16'h00CF, 16'd2, 16'h0010);
    check("R5 idle high", {15'd0, sclk}, 16'd1);
    send(16'hBEEF); send(16'h1234);
    wait_idle();
    expect_rx("R5 mode3 rx", 16'h0000);
    expect_rx("R5 mode3 rx", 16'h0000);

    // R4 code 0 acts as 4 bits, mode 1, external input high
    miso = 1'b1;
    cfg(16'h0040, 16'd2, 16'h0010);
    send(16'h000A);
    wait_idle();
    expect_rx("R4 short code rx", 16'h000F);

    // R5 mode 2, 12-bit, loopback (R11)
    cfg(16'h008B, 16'd2, 16'h0018);
    send(16'h0ABC);
    wait_idle();
    expect_rx("R11 mode2 loopback", 16'h0ABC);

    // R6 R8 R9 fill, overflow, overrun
    cfg(16'h0007, 16'd2, 16'h0008);
    for (int i = 1; i <= 8; i++) send(16'(i * 17));
    wr(5'h08, 16'h00EE);
    rd(5'h0C, d); check("R6 R8 status tx full", d, 16'h0010);
    wr(5'h04, 16'h0018);
    wait_idle();
    rd(5'h0C, d); check("R8 status rx full", d, 16'h000F);
    send(16'h0077);
    wait_idle();
    wr(5'h04, 16'h001C);
    rd(5'h14, d); check("R9 overrun flag", d, 16'h0004);
    check("R9 irq", {15'd0, irq}, 16'd1);
    wr(5'h14, 16'h0000);
    rd(5'h14, d); check("R9 overrun cleared", d, 16'h0000);
    check("R9 irq cleared", {15'd0, irq}, 16'd0);
    for (int i = 1; i <= 8; i++) expect_rx("R6 R9 rx order", 16'(i * 17));
    expect_rx("R7 empty read", 16'h0000);

    // R10 interrupt levels
    wr(5'h04, 16'h0019);
    send(16'h0021); send(16'h0022); send(16'h0023);
    wait_idle();
    check("R10 rx below half", {15'd0, irq}, 16'd0);
    send(16'h0024);
    wait_idle();
    check("R10 rx at half", {15'd0, irq}, 16'd1);
    rd(5'h14, d); check("R10 rx source", d, 16'h0001);
    expect_rx("R7 pop", 16'h0021);
    check("R10 rx dropped below", {15'd0, irq}, 16'd0);
    wr(5'h04, 16'h001A);
    rd(5'h14, d); check("R10 tx source", d, 16'h0002);
    wr(5'h04, 16'h000A);
    for (int i = 0; i < 5; i++) send(16'(16'h31 + i));
    check("R10 tx above half", {15'd0, irq}, 16'd0);
    wr(5'h04, 16'h001A);
    wait_idle();
    expect_rx("R10 drain", 16'h0022);
    expect_rx("R10 drain", 16'h0023);
    expect_rx("R10 drain", 16'h0024);
    for (int i = 0; i < 5; i++) expect_rx("R10 drain", 16'(16'h31 + i));

    // R12 abort and hold while disabled
    cfg(16'h0307, 16'd254, 16'h0018);
    wr(5'h08, 16'h005A);
    repeat (1200) @(negedge clk);
    wr(5'h04, 16'h0008);
    @(negedge clk);
    check("R12 ss_n after stop", {15'd0, ss_n}, 16'd1);
    check("R12 sclk idle after stop", {15'd0, sclk}, 16'd0);
    rd(5'h0C, d); check("R12 nothing stored", d, 16'h0003);
    wr(5'h08, 16'h0033);
    repeat (50) @(negedge clk);
    check("R12 held ss_n", {15'd0, ss_n}, 16'd1);
    rd(5'h0C, d); check("R12 held status", d, 16'h0012);
    wire_q.push_back(16'h0033);
    cfg(16'h0007, 16'd2, 16'h0018);
    wait_idle();
    expect_rx("R12 resumed", 16'h0033);
    check("R4 all frames seen", 16'(wire_q.size()), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule